// File: doc/BRIEF.md
# Shared-Bus Three-Step ALU Sequencer

This block is a small datapath in which a register file, two operand holding registers and an ALU all meet on a single internal bus. Only one source can drive that bus in a cycle. A two-operand operation therefore runs as a fixed sequence. First the A-side source register is moved into the A holding register. Next the B-side source register is moved into the B holding register. Last the ALU result is placed on the bus and written into the destination register.

A requester raises `start_i` while the block is idle. With the request it presents two source indices, a destination index and a 3-bit operation code. A load request instead places an external word on the bus for one cycle and writes it to the destination. Completion is marked by a one-cycle `done_o` pulse. The written value is then held on `result_o` until the next completion, and software-free reads of any register come from a pass-B operation.

The ALU evaluates every function at once and a result multiplexer steered by the operation code picks one. A destination that is also a source is legal, because both operands are already held before the write-back cycle.

Top module: `sbus_alu_seq`

## Requirements
- R1: After reset every register holds 0, `busy_o` and `done_o` are low and `result_o` is 0.
- R2: In any cycle at most one of the three bus drivers (register read, ALU result, external word) is enabled.
- R3: In the first cycle after an ALU request is accepted, the register named by `src_a_i` drives the bus and the A holding register captures it at the closing edge.
- R4: In the second cycle the register named by `src_b_i` drives the bus and the B holding register captures it.
- R5: In the third cycle the ALU result drives the bus and is written to the register named by `dst_i`; `done_o` is high in the cycle after the third rising edge following the accepting edge.
- R6: Operation codes on 16-bit values: 0 gives A+B modulo 2^16, 1 gives A-B modulo 2^16, 2 gives A AND B, 3 gives A OR B, 4 gives A XOR B, 5 gives B, and 6 and 7 give 0.
- R7: A request with `load_i` high writes `imm_i` to the destination in one bus cycle; `done_o` is high in the cycle after the first rising edge following the accepting edge.
- R8: `start_i` is accepted only while idle; a request raised while busy starts nothing, writes no register and adds no `done_o` pulse.
- R9: A destination equal to either source yields the result computed from the values the sources held before the operation.
- R10: `done_o` is high for exactly one cycle per completed request, and `busy_o` is high from the accepting edge until the write-back edge.
- R11: `result_o` equals the value written by the latest completed request and holds it until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled while idle |
| load_i | input | 1 | Request is a load of `imm_i` instead of an ALU operation |
| op_i | input | 3 | ALU operation code |
| src_a_i | input | 3 | A-side source register index |
| src_b_i | input | 3 | B-side source register index |
| dst_i | input | 3 | Destination register index |
| imm_i | input | 16 | External word for load requests |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Value written by the latest completed request |

## Verification
An ALU request completes three rising edges after the edge that accepts it and a load one edge after, so the bench counts falling edges from acceptance and checks that `done_o` first appears at exactly that count. It samples `result_o` in that same cycle and again looks one cycle later for the pulse to have dropped. Register contents are read back through pass-B operations, which complete on the same three-edge schedule, and compared with a model in the bench. This happens after every sweep block and after every request injected while busy.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_PASSB = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPA,
    ST_OPB,
    ST_EXEC,
    ST_LOAD
  } seq_state_e;

  // bus drivers, one-hot when active
  typedef struct packed {
    logic rf;
    logic alu;
    logic ext;
  } bus_drv_t;

  localparam int unsigned OP_W      = 3;
  localparam int unsigned NUM_FUNCS = 1 << OP_W;

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREG   = 8,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (wr_en_i && (wr_addr_i == AW'(g))) begin
        regs_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = regs_q[rd_addr_i];

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] y_o
);

  logic [DATA_W-1:0] res [NUM_FUNCS];

  // every function evaluated in parallel, one picked below
  for (genvar g = 0; g < NUM_FUNCS; g++) begin : g_fn
    if (g == int'(OP_ADD)) begin : g_add
      assign res[g] = a_i + b_i;
    end else if (g == int'(OP_SUB)) begin : g_sub
      assign res[g] = a_i - b_i;
    end else if (g == int'(OP_AND)) begin : g_and
      assign res[g] = a_i & b_i;
    end else if (g == int'(OP_OR)) begin : g_or
      assign res[g] = a_i | b_i;
    end else if (g == int'(OP_XOR)) begin : g_xor
      assign res[g] = a_i ^ b_i;
    end else if (g == int'(OP_PASSB)) begin : g_passb
      assign res[g] = b_i;
    end else begin : g_zero
      assign res[g] = '0;
    end
  end

  assign y_o = res[op_i];

endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREG   = 8,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [AW-1:0]     src_a_i,
  input  logic [AW-1:0]     src_b_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [DATA_W-1:0] imm_i,
  output bus_drv_t          drv_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              ld_a_o,
  output logic              ld_b_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] imm_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e        state_q, state_d;
  logic [AW-1:0]     src_a_q, src_b_q, dst_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] imm_q;
  logic              done_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = load_i ? ST_LOAD : ST_OPA;
      ST_OPA:  state_d = ST_OPB;
      ST_OPB:  state_d = ST_EXEC;
      ST_EXEC: state_d = ST_IDLE;
      ST_LOAD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_a_q <= '0;
      src_b_q <= '0;
      dst_q   <= '0;
      op_q    <= '0;
      imm_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_EXEC) || (state_q == ST_LOAD);
      if (accept) begin
        src_a_q <= src_a_i;
        src_b_q <= src_b_i;
        dst_q   <= dst_i;
        op_q    <= op_i;
        imm_q   <= imm_i;
      end
    end
  end

  always_comb begin
    drv_o     = '0;
    ld_a_o    = 1'b0;
    ld_b_o    = 1'b0;
    wr_en_o   = 1'b0;
    rd_addr_o = src_a_q;
    unique case (state_q)
      ST_OPA: begin
        drv_o.rf = 1'b1;
        ld_a_o   = 1'b1;
      end
      ST_OPB: begin
        drv_o.rf  = 1'b1;
        rd_addr_o = src_b_q;
        ld_b_o    = 1'b1;
      end
      ST_EXEC: begin
        drv_o.alu = 1'b1;
        wr_en_o   = 1'b1;
      end
      ST_LOAD: begin
        drv_o.ext = 1'b1;
        wr_en_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign wr_addr_o = dst_q;
  assign op_o      = op_q;
  assign imm_o     = imm_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

endmodule

// File: rtl/sbus_alu_seq.sv
module sbus_alu_seq
  import sbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREG   = 8,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [AW-1:0]     src_a_i,
  input  logic [AW-1:0]     src_b_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);

  bus_drv_t          drv;
  logic [AW-1:0]     rd_addr, wr_addr;
  logic              ld_a, ld_b, wr_en;
  logic [OP_W-1:0]   alu_op;
  logic [DATA_W-1:0] imm_q, rd_data, alu_y, bus;
  logic [DATA_W-1:0] buf_a_q, buf_b_q, result_q;

  sbus_ctrl #(.DATA_W(DATA_W), .NREG(NREG)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .load_i    (load_i),
    .op_i      (op_i),
    .src_a_i   (src_a_i),
    .src_b_i   (src_b_i),
    .dst_i     (dst_i),
    .imm_i     (imm_i),
    .drv_o     (drv),
    .rd_addr_o (rd_addr),
    .ld_a_o    (ld_a),
    .ld_b_o    (ld_b),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .op_o      (alu_op),
    .imm_o     (imm_q),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  sbus_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (bus)
  );

  sbus_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i  (buf_a_q),
    .b_i  (buf_b_q),
    .op_i (alu_op),
    .y_o  (alu_y)
  );

  // shared bus: AND-OR of gated drivers
  assign bus = ({DATA_W{drv.rf}}  & rd_data)
             | ({DATA_W{drv.alu}} & alu_y)
             | ({DATA_W{drv.ext}} & imm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_a_q  <= '0;
      buf_b_q  <= '0;
      result_q <= '0;
    end else begin
      if (ld_a)  buf_a_q  <= bus;
      if (ld_b)  buf_b_q  <= bus;
      if (wr_en) result_q <= bus;
    end
  end

  assign result_o = result_q;

endmodule

// File: rtl/sbus_seq_checker.sv
module sbus_seq_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o,
  input logic              drv_rf,
  input logic              drv_alu,
  input logic              drv_ext,
  input logic              ld_a,
  input logic              ld_b,
  input logic              wr_en,
  input logic [DATA_W-1:0] bus,
  input logic [DATA_W-1:0] buf_a,
  input logic [DATA_W-1:0] buf_b
);

  assert_one_driver_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drv_rf, drv_alu, drv_ext}));

  assert_capture_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_a |=> (buf_a == $past(bus)));

  assert_a_then_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_a |=> (ld_b && drv_rf));

  assert_capture_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_b |=> (buf_b == $past(bus)));

  assert_b_then_exec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_b |=> (drv_alu && wr_en));

  assert_wb_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (done_o && result_o == $past(bus)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_accept_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(result_o));

endmodule

bind sbus_alu_seq sbus_seq_checker #(.DATA_W(DATA_W)) u_seq_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .drv_rf   (drv.rf),
  .drv_alu  (drv.alu),
  .drv_ext  (drv.ext),
  .ld_a     (ld_a),
  .ld_b     (ld_b),
  .wr_en    (wr_en),
  .bus      (bus),
  .buf_a    (buf_a_q),
  .buf_b    (buf_b_q)
);

// File: tb/sbus_alu_seq_bench.sv
module sbus_alu_seq_bench;

  localparam int DW = 16;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          load = 1'b0;
  logic [2:0]    op = '0;
  logic [2:0]    sa = '0, sb = '0, dst = '0;
  logic [DW-1:0] imm = '0;
  logic          busy, done;
  logic [DW-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [DW-1:0] model [NR];
  logic [DW-1:0] lcg = 16'hACE1;

  always #2.5 clk = ~clk;

  sbus_alu_seq u_sbus_alu_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .load_i(load), .op_i(op),
    .src_a_i(sa), .src_b_i(sb), .dst_i(dst), .imm_i(imm),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [DW-1:0] ref_alu(input logic [2:0] o, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (o)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return b;
      default: return '0;
    endcase
  endfunction

  // issue a request; optionally raise a second start while busy
  task automatic run(input logic ld, input logic [2:0] o, input logic [2:0] a,
                     input logic [2:0] b, input logic [2:0] d, input logic [DW-1:0] v,
                     input string tag, input logic inject = 1'b0);
    logic [DW-1:0] exp;
    int cyc;
    int lat;
    exp = ld ? v : ref_alu(o, model[a], model[b]);
    lat = ld ? 1 : 3;
    @(negedge clk);
    start = 1'b1; load = ld; op = o; sa = a; sb = b; dst = d; imm = v;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 8) begin
      if (inject && cyc == 1) begin
        start = 1'b1; load = 1'b1; dst = 3'd7; imm = ~model[7];
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk({tag, " latency R5 R7"}, DW'(cyc), DW'(lat));
    chk({tag, " R6 R11"}, result, exp);
    model[d] = exp;
    @(negedge clk);
    chk({tag, " pulse R10"}, {15'd0, done}, 16'd0);
    chk({tag, " held R11"}, result, exp);
  endtask

  task automatic readback(input string tag);
    for (int r = 0; r < NR; r++) begin
      run(1'b0, 3'd5, 3'd0, 3'(r), 3'(r), '0, {tag, " readback"});
    end
  endtask

  task automatic reload();
    for (int r = 0; r < NR; r++) begin
      lcg = lcg * 16'd25173 + 16'd13849;
      case (r)
        0: run(1'b1, 3'd0, 3'd0, 3'd0, 3'(r), 16'hFFFF, "R7 load");
        1: run(1'b1, 3'd0, 3'd0, 3'd0, 3'(r), 16'h8000, "R7 load");
        2: run(1'b1, 3'd0, 3'd0, 3'd0, 3'(r), 16'h0001, "R7 load");
        default: run(1'b1, 3'd0, 3'd0, 3'd0, 3'(r), lcg, "R7 load");
      endcase
    end
  endtask

  initial begin
    for (int r = 0; r < NR; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 result", result, 16'd0);
    rst_n = 1'b1;
    readback("R1");

    for (int o = 0; o < 8; o++) begin
      reload();
      for (int a = 0; a < NR; a++) begin
        for (int b = 0; b < NR; b++) begin
          int d;
          d = (a + b + o) % NR;
          if (d == a || d == b)
            run(1'b0, 3'(o), 3'(a), 3'(b), 3'(d), '0, "R3 R4 R9 overlap");
          else
            run(1'b0, 3'(o), 3'(a), 3'(b), 3'(d), '0, "R3 R4 R6");
        end
      end
      readback("R5 regs");
    end

    // start while busy must be ignored
    reload();
    for (int k = 0; k < 4; k++) begin
      run(1'b0, 3'(k), 3'(k), 3'(k + 1), 3'(k + 2), '0, "R8 busy start", 1'b1);
      readback("R8 regs");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule